// File: doc/BRIEF.md
# GPIO Port Register Bank

A 32-pin general-purpose I/O port controlled through a word-wide register interface. Software sets a per-pin direction, a data value for the pins it drives, a two-bit interrupt configuration per pin, an interrupt enable mask and a per-pin edge-select override. The block turns these into the pad output and output-enable vectors and hands the configuration vectors, unchanged, to a separate interrupt detector. That detector reports the events it finds back through a set vector, and the block keeps them in a sticky status register that software clears by writing ones.

Pad inputs pass through a two-flop synchronizer before any read can see them. A read of the data offset mixes the driven value on output pins with the sampled value on input pins. A parameter removes the edge-select register, and its offset then behaves like an empty slot. Requests take one cycle. Read data appears on the cycle after the request and is zero in every other cycle.

Top module: `gpio_regbank`

## Requirements
- R1: After reset every register reads 0, so all pins are inputs (output enables 0, pad outputs 0), the configuration, mask, edge and status vectors are 0, and rdata_o is 0.
- R2: Read data for a request in cycle N is presented on rdata_o in cycle N+1. rdata_o is 0 in any cycle that follows a cycle with no read request.
- R3: A read at byte offset 0x00 returns, per bit, the data register where the direction bit is 1 and the synchronized pad level where it is 0. A write there replaces the data register.
- R4: pad_level_o is pad_in_i delayed by two clock edges. A read at 0x08 returns that level with output-pin bits forced to 0. Writes to 0x08 change nothing.
- R5: pad_oe_o equals the direction register. pad_out_o equals data AND direction, so a pin drives a 1 only while it is an output.
- R6: Offset 0x0C holds configuration bits [31:0] (pins 0 to 15, two bits per pin with pin i at bits 2i+1:2i) and 0x10 holds bits [63:32] (pins 16 to 31). A write to either one replaces only its own half of irq_cfg_o.
- R7: Offset 0x14 is a read/write mask that drives irq_mask_o.
- R8: Offset 0x18 is the status register. A bit is set when the same bit of irq_set_i is 1 and cleared by writing 1 to it. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R9: With HAS_EDGE_SEL=1, offset 0x1C is a read/write register that drives irq_edge_o. With HAS_EDGE_SEL=0 it reads 0, writes are ignored and irq_edge_o stays 0.
- R10: Offsets above 0x1C, and any address with bits [1:0] not equal to 0, read 0. Writes to them leave every register unchanged.
- R11: Offset 0x04 is the read/write direction register. A bit value of 1 makes the pin an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request valid for one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| pad_in_i | input | DATA_W | Asynchronous pad levels |
| pad_out_o | output | DATA_W | Pad drive values |
| pad_oe_o | output | DATA_W | Pad output enables |
| pad_level_o | output | DATA_W | Synchronized pad levels |
| irq_cfg_o | output | 2*DATA_W | Interrupt configuration, two bits per pin |
| irq_mask_o | output | DATA_W | Interrupt mask |
| irq_edge_o | output | DATA_W | Edge-select override |
| irq_set_i | input | DATA_W | Event pulses from the detector |
| irq_status_o | output | DATA_W | Sticky interrupt status |

## Verification
The assertions check the following on every cycle: the idle value of rdata_o, the effect of direction, mask and configuration-half writes on their output vectors one cycle later, set-over-clear priority in the status register, and that misaligned writes leave the configuration outputs alone. Other behaviour can only be shown by the bench scenarios: the per-bit mix of a data read, masking of the pad-status read, the two-edge synchronizer latency, the behaviour of a variant built without the edge register, and reads of empty offsets. These depend on values set up over several earlier transactions.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

  localparam int unsigned OFS_DATA   = 'h00;
  localparam int unsigned OFS_DIR    = 'h04;
  localparam int unsigned OFS_PSR    = 'h08;
  localparam int unsigned OFS_CFG_LO = 'h0C;
  localparam int unsigned OFS_CFG_HI = 'h10;
  localparam int unsigned OFS_MASK   = 'h14;
  localparam int unsigned OFS_STAT   = 'h18;
  localparam int unsigned OFS_EDGE   = 'h1C;

  // word index order matches the byte offsets above
  typedef enum logic [3:0] {
    REG_DATA   = 4'd0,
    REG_DIR    = 4'd1,
    REG_PSR    = 4'd2,
    REG_CFG_LO = 4'd3,
    REG_CFG_HI = 4'd4,
    REG_MASK   = 4'd5,
    REG_STAT   = 4'd6,
    REG_EDGE   = 4'd7,
    REG_NONE   = 4'd8
  } reg_sel_e;

endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W       = 6,
  parameter bit          HAS_EDGE_SEL = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);

  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REG_EDGE);

  logic [IDX_W-1:0] idx;
  logic             aligned;

  assign idx     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    sel_o = REG_NONE;
    if (aligned && idx <= LAST_IDX) begin
      sel_o = reg_sel_e'(4'(idx));
    end
    if (!HAS_EDGE_SEL && sel_o == REG_EDGE) begin
      sel_o = REG_NONE;
    end
  end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter bit          HAS_EDGE_SEL = 1'b1,
  localparam int unsigned CFG_W       = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] irq_set_i,
  output logic [DATA_W-1:0] dr_o,
  output logic [DATA_W-1:0] dir_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] edge_sel_o
);

  logic [DATA_W-1:0] dr_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, stat_q, stat_clr;

  assign stat_clr = (wr_i && sel_i == REG_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_q     <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      stat_q   <= '0;
    end else begin
      if (wr_i && sel_i == REG_DATA)   dr_q     <= wdata_i;
      if (wr_i && sel_i == REG_DIR)    dir_q    <= wdata_i;
      if (wr_i && sel_i == REG_CFG_LO) cfg_lo_q <= wdata_i;
      if (wr_i && sel_i == REG_CFG_HI) cfg_hi_q <= wdata_i;
      if (wr_i && sel_i == REG_MASK)   mask_q   <= wdata_i;
      // new events win over a same-cycle clear
      stat_q <= (stat_q & ~stat_clr) | irq_set_i;
    end
  end

  generate
    if (HAS_EDGE_SEL) begin : g_edge
      logic [DATA_W-1:0] edge_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) edge_q <= '0;
        else if (wr_i && sel_i == REG_EDGE) edge_q <= wdata_i;
      end
      assign edge_sel_o = edge_q;
    end else begin : g_no_edge
      assign edge_sel_o = '0;
    end
  endgenerate

  assign dr_o   = dr_q;
  assign dir_o  = dir_q;
  assign cfg_o  = {cfg_hi_q, cfg_lo_q};
  assign mask_o = mask_q;
  assign stat_o = stat_q;

endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CFG_W = 2 * DATA_W
) (
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] dr_i,
  input  logic [DATA_W-1:0] dir_i,
  input  logic [DATA_W-1:0] psr_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] stat_i,
  input  logic [DATA_W-1:0] edge_sel_i,
  output logic [DATA_W-1:0] rdata_o
);

  always_comb begin
    unique case (sel_i)
      REG_DATA:   rdata_o = (dr_i & dir_i) | (psr_i & ~dir_i);
      REG_DIR:    rdata_o = dir_i;
      REG_PSR:    rdata_o = psr_i & ~dir_i;
      REG_CFG_LO: rdata_o = cfg_i[DATA_W-1:0];
      REG_CFG_HI: rdata_o = cfg_i[CFG_W-1:DATA_W];
      REG_MASK:   rdata_o = mask_i;
      REG_STAT:   rdata_o = stat_i;
      REG_EDGE:   rdata_o = edge_sel_i;
      default:    rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned ADDR_W       = 6,
  parameter bit          HAS_EDGE_SEL = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [DATA_W-1:0]     pad_in_i,
  output logic [DATA_W-1:0]     pad_out_o,
  output logic [DATA_W-1:0]     pad_oe_o,
  output logic [DATA_W-1:0]     pad_level_o,
  output logic [2*DATA_W-1:0]   irq_cfg_o,
  output logic [DATA_W-1:0]     irq_mask_o,
  output logic [DATA_W-1:0]     irq_edge_o,
  input  logic [DATA_W-1:0]     irq_set_i,
  output logic [DATA_W-1:0]     irq_status_o
);

  localparam int unsigned CFG_W = 2 * DATA_W;

  reg_sel_e          sel;
  logic              wr, rd;
  logic [DATA_W-1:0] psr, dr, dir, mask, stat, edge_sel, rd_mux, rdata_q;
  logic [CFG_W-1:0]  cfg;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  gpio_decode #(.ADDR_W(ADDR_W), .HAS_EDGE_SEL(HAS_EDGE_SEL)) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  gpio_sync #(.WIDTH(DATA_W), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (psr)
  );

  gpio_regs #(.DATA_W(DATA_W), .HAS_EDGE_SEL(HAS_EDGE_SEL)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr),
    .sel_i      (sel),
    .wdata_i    (wdata_i),
    .irq_set_i  (irq_set_i),
    .dr_o       (dr),
    .dir_o      (dir),
    .cfg_o      (cfg),
    .mask_o     (mask),
    .stat_o     (stat),
    .edge_sel_o (edge_sel)
  );

  gpio_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .sel_i      (sel),
    .dr_i       (dr),
    .dir_i      (dir),
    .psr_i      (psr),
    .cfg_i      (cfg),
    .mask_i     (mask),
    .stat_i     (stat),
    .edge_sel_i (edge_sel),
    .rdata_o    (rd_mux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd ? rd_mux : '0;
  end

  assign rdata_o      = rdata_q;
  assign pad_out_o    = dr & dir;
  assign pad_oe_o     = dir;
  assign pad_level_o  = psr;
  assign irq_cfg_o    = cfg;
  assign irq_mask_o   = mask;
  assign irq_edge_o   = edge_sel;
  assign irq_status_o = stat;

endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [DATA_W-1:0]   pad_oe_o,
  input logic [2*DATA_W-1:0] irq_cfg_o,
  input logic [DATA_W-1:0]   irq_mask_o,
  input logic [DATA_W-1:0]   irq_set_i,
  input logic [DATA_W-1:0]   irq_status_o
);

  localparam int unsigned CW = 2 * DATA_W;

  logic wr;
  assign wr = req_i && we_i;

  a_r2_idle_rdata_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> rdata_o == '0);

  a_r11_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(OFS_DIR)) |=> pad_oe_o == $past(wdata_i));

  a_r6_cfg_lo_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(OFS_CFG_LO)) |=>
      (irq_cfg_o[DATA_W-1:0] == $past(wdata_i)) &&
      (irq_cfg_o[CW-1:DATA_W] == $past(irq_cfg_o[CW-1:DATA_W])));

  a_r6_cfg_hi_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(OFS_CFG_HI)) |=>
      (irq_cfg_o[CW-1:DATA_W] == $past(wdata_i)) &&
      (irq_cfg_o[DATA_W-1:0] == $past(irq_cfg_o[DATA_W-1:0])));

  a_r7_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(OFS_MASK)) |=> irq_mask_o == $past(wdata_i));

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_set_i) |=> (irq_status_o & $past(irq_set_i)) == $past(irq_set_i));

  a_r10_misaligned_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i[1:0] != 2'b00) |=>
      $stable(irq_cfg_o) && $stable(irq_mask_o) && $stable(pad_oe_o));

endmodule

bind gpio_regbank gpio_regbank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .pad_oe_o     (pad_oe_o),
  .irq_cfg_o    (irq_cfg_o),
  .irq_mask_o   (irq_mask_o),
  .irq_set_i    (irq_set_i),
  .irq_status_o (irq_status_o)
);

// File: tb/test_gpio_regbank.sv
`timescale 1ns/1ps
module test_gpio_regbank;

  localparam int DW = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, pad_in = '0, irq_set = '0;

  logic [DW-1:0]   rdata, pad_out, pad_oe, pad_level, mask, edge_sel, status;
  logic [2*DW-1:0] cfg;
  logic [DW-1:0]   rdata2, pad_out2, pad_oe2, pad_level2, mask2, edge_sel2, status2;
  logic [2*DW-1:0] cfg2;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [DW-1:0]   m_dr = '0, m_dir = '0, m_mask = '0, m_stat = '0, m_edge = '0, m_psr = '0;
  logic [2*DW-1:0] m_cfg = '0;

  always #2 clk = ~clk;

  gpio_regbank #(.DATA_W(DW), .ADDR_W(AW), .HAS_EDGE_SEL(1'b1)) i_gpio_regbank (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .pad_level_o(pad_level), .irq_cfg_o(cfg), .irq_mask_o(mask), .irq_edge_o(edge_sel),
    .irq_set_i(irq_set), .irq_status_o(status));

  gpio_regbank #(.DATA_W(DW), .ADDR_W(AW), .HAS_EDGE_SEL(1'b0)) i_gpio_regbank_noedge (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata2), .pad_in_i(pad_in), .pad_out_o(pad_out2), .pad_oe_o(pad_oe2),
    .pad_level_o(pad_level2), .irq_cfg_o(cfg2), .irq_mask_o(mask2), .irq_edge_o(edge_sel2),
    .irq_set_i(irq_set), .irq_status_o(status2));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a, input bit has_edge);
    if (a[1:0] != 2'b00) return '0;
    case (a[AW-1:2])
      4'd0: return (m_dr & m_dir) | (m_psr & ~m_dir);
      4'd1: return m_dir;
      4'd2: return m_psr & ~m_dir;
      4'd3: return m_cfg[DW-1:0];
      4'd4: return m_cfg[2*DW-1:DW];
      4'd5: return m_mask;
      4'd6: return m_stat;
      4'd7: return has_edge ? m_edge : '0;
      default: return '0;
    endcase
  endfunction

  task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (a[1:0] == 2'b00) begin
      case (a[AW-1:2])
        4'd0: m_dr = d;
        4'd1: m_dir = d;
        4'd3: m_cfg[DW-1:0] = d;
        4'd4: m_cfg[2*DW-1:DW] = d;
        4'd5: m_mask = d;
        4'd6: m_stat = m_stat & ~d;
        4'd7: m_edge = d;
        default: ;
      endcase
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    model_write(a, d);
    chk("R2 rdata zero after write", 64'(rdata), 64'd0);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    chk(tag, 64'(rdata), 64'(exp_read(a, 1'b1)));
    chk({tag, " (no edge variant)"}, 64'(rdata2), 64'(exp_read(a, 1'b0)));
  endtask

  task automatic set_pads(input logic [DW-1:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
    m_psr = v;
  endtask

  task automatic check_outputs(input string tag);
    chk({tag, " R5 pad_oe"}, 64'(pad_oe), 64'(m_dir));
    chk({tag, " R5 pad_out"}, 64'(pad_out), 64'(m_dr & m_dir));
    chk({tag, " R6 cfg"}, cfg, m_cfg);
    chk({tag, " R7 mask"}, 64'(mask), 64'(m_mask));
    chk({tag, " R9 edge"}, 64'(edge_sel), 64'(m_edge));
    chk({tag, " R9 no-edge output"}, 64'(edge_sel2), 64'd0);
    chk({tag, " R8 status"}, 64'(status), 64'(m_stat));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", 64'(rdata), 64'd0);
    chk("R1 pad_oe", 64'(pad_oe), 64'd0);
    chk("R1 pad_out", 64'(pad_out), 64'd0);
    chk("R1 cfg", cfg, 64'd0);
    chk("R1 status", 64'(status), 64'd0);
    for (int i = 0; i < 8; i++) bus_read(AW'(i * 4), "R1 reset read");

    // R4 synchronizer latency
    @(negedge clk);
    pad_in = 32'hA5A5_0F0F;
    chk("R4 level before edges", 64'(pad_level), 64'd0);
    @(negedge clk);
    chk("R4 level after one edge", 64'(pad_level), 64'd0);
    @(negedge clk);
    chk("R4 level after two edges", 64'(pad_level), 64'hA5A5_0F0F);
    m_psr = pad_in;

    // R3/R4/R5/R11 directed mix
    bus_write(AW'('h04), 32'hFFFF_0000);
    bus_write(AW'('h00), 32'h1234_5678);
    bus_read(AW'('h00), "R3 data mix");
    bus_read(AW'('h08), "R4 pad status masked");
    bus_write(AW'('h08), 32'hFFFF_FFFF);
    bus_read(AW'('h08), "R4 pad status write ignored");
    bus_read(AW'('h04), "R11 direction readback");
    check_outputs("directed");

    // R6 halves
    bus_write(AW'('h0C), 32'hDEAD_BEEF);
    bus_write(AW'('h10), 32'h0BAD_F00D);
    bus_write(AW'('h0C), 32'h1111_2222);
    chk("R6 high half kept", 64'(cfg[63:32]), 64'h0BAD_F00D);
    bus_read(AW'('h0C), "R6 low half read");
    bus_read(AW'('h10), "R6 high half read");

    // R9 edge select both variants
    bus_write(AW'('h1C), 32'hCAFE_0001);
    bus_read(AW'('h1C), "R9 edge readback");
    chk("R9 no-edge output stays 0", 64'(edge_sel2), 64'd0);

    // R8 set, clear, set-wins
    @(negedge clk); irq_set = 32'h0000_0005;
    @(negedge clk); irq_set = '0;
    m_stat = 32'h5;
    chk("R8 set sticky", 64'(status), 64'h5);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'('h18); wdata = 32'h5; irq_set = 32'h4;
    @(negedge clk);
    req = 1'b0; we = 1'b0; irq_set = '0;
    m_stat = 32'h4;
    chk("R8 set wins over clear", 64'(status), 64'h4);
    bus_read(AW'('h18), "R8 status read");
    bus_write(AW'('h18), 32'h4);
    chk("R8 cleared", 64'(status), 64'd0);

    // R10 unknown and misaligned
    bus_write(AW'('h24), 32'hFFFF_FFFF);
    bus_write(AW'('h15), 32'hFFFF_FFFF);
    bus_read(AW'('h24), "R10 unknown offset");
    bus_read(AW'('h05), "R10 misaligned offset");
    check_outputs("R10 after ignored writes");

    // R2 idle cycle
    @(negedge clk);
    chk("R2 idle rdata", 64'(rdata), 64'd0);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int unsigned pick;
      logic [AW-1:0] a;
      pick = $urandom_range(0, 15);
      if (pick < 8)       a = AW'(pick * 4);
      else if (pick < 12) a = AW'('h20 + (pick - 8) * 4);
      else                a = AW'($urandom_range(0, 63) | 1);
      if ((it % 7) == 0) set_pads($urandom());
      if ($urandom_range(0, 1) == 0) bus_write(a, $urandom());
      else                           bus_read(a, "R3/R10 random read");
      if ((it % 25) == 0) check_outputs("random");
    end
    check_outputs("final");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule